// File: doc/BRIEF.md
# Paged Operand Address Resolver

This block works out where the operand of a memory-reference instruction lives on a machine with 17-bit words and 16-bit addresses. Memory is divided into pages of 1K words, and the page number is the top six address bits. The instruction carries a 10-bit word offset and two flags. The first flag picks the page: either the page that holds the instruction, or page zero. The second flag says whether the address formed this way is the operand itself or the address of a pointer word.

A pointer word holds a full 16-bit address in its low sixteen bits. Its top bit says whether the word it names is a further pointer. The resolver follows such a chain through a one-cycle-latency synchronous read port. It issues one read, waits for the data, and only then decides whether to read again. It stops at the first pointer whose top bit is clear. It then presents the final address, a one-cycle done strobe and the number of pointer words it read.

Hardware places no limit on the length of a chain, so a configurable depth limit ends a chain that never terminates. When that limit is hit, the result carries an error flag instead of spinning forever. The caller pulses start only while the block is idle.

Top module: `oper_addr_resolver`

## Requirements
- R1: The direct address is the 10-bit offset in instruction bits 9:0. It is placed in page zero when instruction bit 10 is 1, and in the page of `instr_addr` (bits 15:10) when bit 10 is 0.
- R2: When instruction bit 11 is 0, `done` pulses in the cycle right after the start edge. `res_addr` is then the direct address, `levels` is 0, `err` is 0, and no read is issued.
- R3: When instruction bit 11 is 1, the block issues single-cycle reads. `rd_req` is high for one cycle and `rd_addr` holds the pointer address. The returned word is used in the following cycle, and a new read is issued only after that.
- R4: When a returned pointer has bit 16 set, its bits 15:0 become the next read address. When bit 16 is clear, its bits 15:0 are the final `res_addr`.
- R5: `levels` equals the number of pointer words read. With L pointer reads, `done` rises 2L clock edges after the start edge (L = 0 for direct).
- R6: If `MAX_DEPTH` pointers have been read and the last one still has bit 16 set, the block finishes with `err` = 1 and `levels` = `MAX_DEPTH`. `res_addr` is then bits 15:0 of that last pointer.
- R7: A start pulse that arrives while a chain is being resolved is ignored. It does not change the reads or the result of the chain in progress.
- R8: `done` is a one-cycle pulse. `res_addr`, `levels` and `err` hold their values from that pulse until the next result completes.
- R9: After reset, `done`, `err` and `rd_req` are 0, and `res_addr` and `levels` are 0.
- R10: Instruction bits 16:12 (the operation code) have no effect on the reads or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin resolving; honoured only when idle |
| instr_word | input | 17 | Instruction word (offset, page flag, indirect flag) |
| instr_addr | input | 16 | Address the instruction was fetched from |
| rd_req | output | 1 | Pointer read request, one cycle |
| rd_addr | output | 16 | Pointer read address |
| rd_data | input | 17 | Read data, valid the cycle after `rd_req` |
| done | output | 1 | Result strobe |
| err | output | 1 | Depth limit reached on the last result |
| res_addr | output | 16 | Resolved operand address |
| levels | output | LVL_W = clog2(MAX_DEPTH+1) | Pointer words read for the last result |

## Verification
Internal state in this block is limited to the walk state, the current pointer and the level count. Any fault in these shows at the ports within two cycles. A wrong pointer register shows up as a wrong `rd_addr` at the very next request. A miscounted level shifts `done` by two edges or changes `levels` at the strobe. A wrong walk state shows as a doubled or missing `rd_req`. The bench therefore compares every output against its reference model on every cycle. An error in the page or indirect decode is caught at the first `done` or the first read of the affected instruction.

// File: rtl/res_pkg.sv
package res_pkg;
  localparam int WORD_W    = 17;
  localparam int ADDR_W    = 16;
  localparam int OFF_W     = 10;
  localparam int PAGE_W    = ADDR_W - OFF_W;
  localparam int BIT_ZPAGE = 10;
  localparam int BIT_INDIR = 11;
  localparam int BIT_CHAIN = WORD_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/res_rst_sync.sv
module res_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/res_direct_addr.sv
module res_direct_addr import res_pkg::*; (
  input  logic [WORD_W-1:0] instr_word,
  input  logic [ADDR_W-1:0] instr_addr,
  output logic [ADDR_W-1:0] dir_addr,
  output logic              indirect
);
  logic [PAGE_W-1:0] page_sel;

  always_comb begin
    page_sel = instr_word[BIT_ZPAGE] ? '0 : instr_addr[ADDR_W-1:OFF_W];
    dir_addr = {page_sel, instr_word[OFF_W-1:0]};
    indirect = instr_word[BIT_INDIR];
  end
endmodule

// File: rtl/res_chain_fsm.sv
module res_chain_fsm import res_pkg::*; #(
  parameter int MAX_DEPTH = 64,
  parameter int LVL_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              indirect,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              fin_valid,
  output logic              fin_err,
  output logic [ADDR_W-1:0] fin_addr,
  output logic [LVL_W-1:0]  fin_levels
);
  localparam logic [LVL_W-1:0] LVL_LIMIT = LVL_W'(MAX_DEPTH);

  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [LVL_W-1:0]  lvl_inc;
  logic              chain_more;
  logic              at_limit;

  always_comb begin
    lvl_inc    = lvl_q + LVL_W'(1);
    chain_more = rd_data[BIT_CHAIN];
    at_limit   = (lvl_inc == LVL_LIMIT);
    state_d    = state_q;
    ptr_d      = ptr_q;
    lvl_d      = lvl_q;
    fin_valid  = 1'b0;
    fin_err    = 1'b0;
    fin_addr   = dir_addr;
    fin_levels = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (indirect) begin
            state_d = ST_ISSUE;
            ptr_d   = dir_addr;
            lvl_d   = '0;
          end else begin
            fin_valid = 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        fin_addr   = rd_data[ADDR_W-1:0];
        fin_levels = lvl_inc;
        if (!chain_more || at_limit) begin
          state_d   = ST_IDLE;
          fin_valid = 1'b1;
          fin_err   = chain_more;
        end else begin
          state_d = ST_ISSUE;
          ptr_d   = rd_data[ADDR_W-1:0];
          lvl_d   = lvl_inc;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      lvl_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      lvl_q   <= lvl_d;
    end
  end

  assign rd_req  = (state_q == ST_ISSUE);
  assign rd_addr = ptr_q;
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/oper_addr_resolver.sv
module oper_addr_resolver import res_pkg::*; #(
  parameter  int MAX_DEPTH = 64,
  localparam int LVL_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [ADDR_W-1:0] instr_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] res_addr,
  output logic [LVL_W-1:0]  levels
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] dir_addr;
  logic              indirect;
  logic              busy;
  logic              fin_valid;
  logic              fin_err;
  logic [ADDR_W-1:0] fin_addr;
  logic [LVL_W-1:0]  fin_levels;

  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [ADDR_W-1:0] res_q, res_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;

  res_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  res_direct_addr u_dir (
    .instr_word (instr_word),
    .instr_addr (instr_addr),
    .dir_addr   (dir_addr),
    .indirect   (indirect)
  );

  res_chain_fsm #(.MAX_DEPTH(MAX_DEPTH), .LVL_W(LVL_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .indirect   (indirect),
    .dir_addr   (dir_addr),
    .rd_data    (rd_data),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .busy       (busy),
    .fin_valid  (fin_valid),
    .fin_err    (fin_err),
    .fin_addr   (fin_addr),
    .fin_levels (fin_levels)
  );

  always_comb begin
    done_d = fin_valid;
    err_d  = err_q;
    res_d  = res_q;
    lvl_d  = lvl_q;
    if (fin_valid) begin
      err_d = fin_err;
      res_d = fin_addr;
      lvl_d = fin_levels;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      res_q  <= '0;
      lvl_q  <= '0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      res_q  <= res_d;
      lvl_q  <= lvl_d;
    end
  end

  assign done     = done_q;
  assign err      = err_q;
  assign res_addr = res_q;
  assign levels   = lvl_q;
endmodule

// File: rtl/res_checks.sv
module res_checks import res_pkg::*; #(
  parameter int MAX_DEPTH = 64,
  parameter int LVL_W     = $clog2(MAX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [WORD_W-1:0] instr_word,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] res_addr,
  input logic [LVL_W-1:0]  levels
);
  // R3: reads never come back to back
  a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R3: pointer address steady while the request waits for data
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> $stable(rd_addr));

  // R2: direct request completes next cycle with no levels
  a_r2_direct_quick: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !instr_word[BIT_INDIR]) |=> (done && levels == '0 && !err));

  // R8: done is a single-cycle strobe
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: result fields only move with the strobe
  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_addr) && $stable(levels) && $stable(err)));

  // R6: error appears only at the depth limit
  a_r6_err_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (levels == LVL_W'(MAX_DEPTH)));

  // R5: level count never exceeds the limit
  a_r5_levels_cap: assert property (@(posedge clk) disable iff (!rst_n)
    levels <= LVL_W'(MAX_DEPTH));

  // R7: no read in the cycle a result is presented
  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
endmodule

bind oper_addr_resolver res_checks #(.MAX_DEPTH(MAX_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .busy       (busy),
  .instr_word (instr_word),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .done       (done),
  .err        (err),
  .res_addr   (res_addr),
  .levels     (levels)
);

// File: tb/test_oper_addr_resolver.sv
module test_oper_addr_resolver;
  localparam int MAXD  = 8;
  localparam int LVLW  = $clog2(MAXD + 1);

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [16:0] instr_word;
  logic [15:0] instr_addr;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic [16:0] rd_data;
  logic        done;
  logic        err;
  logic [15:0] res_addr;
  logic [LVLW-1:0] levels;

  int n_chk;
  int n_fail;
  int cyc;

  logic [16:0] mem [int];

  oper_addr_resolver #(.MAX_DEPTH(MAXD)) i_oper_addr_resolver (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .instr_word (instr_word),
    .instr_addr (instr_addr),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .done       (done),
    .err        (err),
    .res_addr   (res_addr),
    .levels     (levels)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [16:0] mem_rd(int a);
    if (mem.exists(a)) return mem[a];
    return 17'd0;
  endfunction

  // memory with one cycle of read latency
  initial rd_data = '0;
  always @(posedge clk) if (rd_req) rd_data <= mem_rd(int'(rd_addr));

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_active;
  int          m_step, m_total, m_lvls;
  int          m_chain[$];
  bit          m_exp_done, m_exp_req, m_exp_err;
  int          m_exp_addr, m_exp_res, m_exp_lvl;
  int          r_fin, r_lvl;
  bit          r_err;

  task automatic resolve(logic [16:0] iw, logic [15:0] ia);
    int a;
    logic [16:0] w;
    a = iw[10] ? int'(iw[9:0]) : ((int'(ia) / 1024) * 1024 + int'(iw[9:0]));
    m_chain.delete();
    r_lvl = 0;
    r_err = 0;
    if (iw[11]) begin
      forever begin
        m_chain.push_back(a);
        w = mem_rd(a);
        r_lvl++;
        a = int'(w[15:0]);
        if (!w[16]) break;
        if (r_lvl == MAXD) begin r_err = 1; break; end
      end
    end
    r_fin = a;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_exp_done = 0; m_exp_req = 0; m_exp_err = 0;
      m_exp_res = 0; m_exp_lvl = 0; m_exp_addr = 0;
    end else begin
      m_exp_done = 0;
      m_exp_req  = 0;
      if (m_active) begin
        m_step++;
        if (m_step == m_total) begin
          m_active = 0; m_exp_done = 1;
          m_exp_res = r_fin; m_exp_lvl = m_lvls; m_exp_err = r_err;
        end else if (m_step % 2 == 0) begin
          m_exp_req = 1; m_exp_addr = m_chain[m_step / 2];
        end
      end else if (start) begin
        resolve(instr_word, instr_addr);
        m_lvls = r_lvl; m_total = 2 * r_lvl; m_step = 0;
        if (r_lvl == 0) begin
          m_exp_done = 1; m_exp_res = r_fin; m_exp_lvl = 0; m_exp_err = 0;
        end else begin
          m_active = 1; m_exp_req = 1; m_exp_addr = m_chain[0];
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk(done == 0 && err == 0 && rd_req == 0 && res_addr == 0 && levels == 0,
          "R9 reset state", {done, err, rd_req, res_addr}, 0);
    end else begin
      chk(rd_req == m_exp_req, "R3 read request", rd_req, m_exp_req);
      if (m_exp_req) chk(int'(rd_addr) == m_exp_addr, "R4 read address", rd_addr, m_exp_addr);
      chk(done == m_exp_done, "R5 done timing", done, m_exp_done);
      chk(int'(res_addr) == m_exp_res, "R1/R8 result address", res_addr, m_exp_res);
      chk(int'(levels) == m_exp_lvl, "R5 levels", levels, m_exp_lvl);
      chk(err == m_exp_err, "R6 error flag", err, m_exp_err);
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run(logic [16:0] iw, logic [15:0] ia);
    @(negedge clk);
    instr_word = iw; instr_addr = ia; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_active) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [16:0] mk(logic [4:0] op, bit ind, bit zp, logic [9:0] off);
    return {op, ind, zp, off};
  endfunction

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; start = 1'b0; instr_word = '0; instr_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R2: direct, current page (page 5)
    run(mk(5'o21, 0, 0, 10'o0777), 16'o013004);
    chk(res_addr == 16'o012777, "R1 current page", res_addr, 16'o012777);
    // R1/R2: direct, zero page
    run(mk(5'o22, 0, 1, 10'o0404), 16'o013004);
    chk(res_addr == 16'o000404, "R2 zero page direct", res_addr, 16'o000404);

    // R3/R4: one indirect level through zero page
    mem[16'o000100] = {1'b0, 16'o054321};
    run(mk(5'o02, 1, 1, 10'o0100), 16'o170000);
    chk(res_addr == 16'o054321 && levels == 1, "R4 single pointer", res_addr, 16'o054321);

    // R4/R5: three-level chain from the current page
    mem[16'o024200] = {1'b1, 16'o100010};
    mem[16'o100010] = {1'b1, 16'o003333};
    mem[16'o003333] = {1'b0, 16'o177776};
    run(mk(5'o25, 1, 0, 10'o0200), 16'o025555);
    chk(res_addr == 16'o177776 && levels == 3, "R5 three levels", levels, 3);

    // R6: self-referencing pointer hits the limit
    mem[16'o000300] = {1'b1, 16'o000300};
    run(mk(5'o03, 1, 1, 10'o0300), 16'o001000);
    chk(err == 1'b1 && int'(levels) == MAXD, "R6 depth limit", levels, MAXD);

    // R8: a clean result after an error clears the flag
    run(mk(5'o10, 0, 1, 10'o0001), 16'o000000);
    chk(err == 1'b0, "R8 error cleared by next result", err, 0);

    // R7: start pulse in the middle of a chain is ignored
    @(negedge clk);
    instr_word = mk(5'o25, 1, 0, 10'o0200); instr_addr = 16'o025555; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    instr_word = mk(5'o21, 0, 1, 10'o0777); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_active) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(res_addr == 16'o177776 && levels == 3, "R7 busy start ignored", res_addr, 16'o177776);

    // R10: opcode bits do not matter
    for (int k = 0; k < 32; k++) begin
      run(mk(5'(k), 1, 0, 10'o0200), 16'o025555);
      chk(res_addr == 16'o177776, "R10 opcode ignored (indirect)", res_addr, 16'o177776);
      run(mk(5'(k), 0, 0, 10'o0012), 16'o176543);
      chk(res_addr == 16'o176012, "R10 opcode ignored (direct)", res_addr, 16'o176012);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule